// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the control side of a small parallel NOR-style flash. It watches write cycles on a synchronous bus and walks an unlock state machine over the bus address and data of each cycle. It recognises three commands: program one byte, erase one sector, and erase the whole array. An accepted command starts a timed stand-in for the embedded algorithm, which runs on a small internal byte array split into equal sectors. When the operation completes, the result is committed to the array.

While an operation runs, or after it has failed on its timeout, a read does not return array data. It returns a status byte instead: a polling bit, two toggle bits and a timeout flag. The ready output is low for the length of the operation. Each sector has a protect input, and a command aimed at a protected sector is refused without any busy period. A reset data value returns the unlock machine to read mode, and it also clears a failed operation.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ready is high and every array byte reads as 0xFF.
- R2: The writes 0x555/0xAA, 0x2AA/0x55 and 0x555/0xA0, followed by a fourth write of data D to address A, program array byte A[5:0]. The new value is the old value AND D. Unlock cycles compare all 11 address bits.
- R3: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 and 0x555/0x10 erase every unprotected sector to 0xFF. Protected sectors keep their contents.
- R4: The same five lead-in cycles, followed by data 0x30 at any address, erase only the sector chosen by that address's bits [5:4] to 0xFF.
- R5: Data 0xF0 at any unlock position (every cycle except the program data cycle) returns to read mode. So does any cycle that does not match the expected address and data. Neither has any effect on the array.
- R6: Ready falls at the second rising edge after the final write and stays low for exactly PROG_CYC cycles for a program, or ERASE_CYC cycles for an erase.
- R7: While ready is low, a read returns a status byte. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase. Bit 6 reads 0 on the first status read of an operation and inverts on every later status read.
- R8: Bit 2 of the status byte follows bit 6 during an erase and is 0 during a program. Bits 4, 3, 1 and 0 are always 0.
- R9: Every write is ignored while ready is low, including 0xF0, with one exception: 0xF0 is accepted in the timed-out state (R11).
- R10: prot_mask bit i protects sector i. A program or sector erase aimed at a protected sector, or a chip erase with all sectors protected, is refused: ready stays high and the array is unchanged.
- R11: If tmo_limit is nonzero and less than the operation length, the operation stops after tmo_limit busy cycles without changing the array. Ready then stays low and status bit 5 reads 1 until a write of 0xF0. If tmo_limit is 0 or at least the operation length, the operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 11 | Bus address for reads and writes |
| wdata | input | 8 | Write data |
| prot_mask | input | NSECT | Per-sector protect flags |
| tmo_limit | input | TMO_W | Busy-cycle timeout limit, 0 disables it |
| rdata | output | 8 | Registered read data, updated the edge after rd_en |
| ready | output | 1 | High when no operation is running or failed |

## Verification
The bench goes after four groups of corner cases.

Abandoned sequences: a reset value or a mismatched cycle partway through an unlock. A decoder that kept partial state here would let a later stray write program a byte.

Protection and busy lockout: a chip erase with one protected sector, followed by a program and a reset written during the busy window. A design that erased protected sectors, or accepted writes while busy, would leave 0x00 or lost data where 0xFF or old data belongs.

Timeout boundary: a limit one short of the operation length and a limit exactly equal to it. An off-by-one compare would fail the second case or complete the first.

Status bytes: exact values on the first and second status reads. A design with a wrong toggle start value, or with bit 2 active during a program, would show a different byte.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;

  localparam int BUS_AW = 11;

  localparam logic [BUS_AW-1:0] UNLK_A = 11'h555;
  localparam logic [BUS_AW-1:0] UNLK_B = 11'h2AA;

  localparam logic [7:0] D_KEY1 = 8'hAA;
  localparam logic [7:0] D_KEY2 = 8'h55;
  localparam logic [7:0] D_PGM  = 8'hA0;
  localparam logic [7:0] D_ERS  = 8'h80;
  localparam logic [7:0] D_CHIP = 8'h10;
  localparam logic [7:0] D_SECT = 8'h30;
  localparam logic [7:0] D_RST  = 8'hF0;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  typedef struct packed {
    op_e               kind;
    logic [BUS_AW-1:0] addr;
    logic [7:0]        data;
  } cmd_t;

  // Programming can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] d);
    return old_v & d;
  endfunction

  // Status byte shown on reads while an operation is busy or failed.
  function automatic logic [7:0] status_byte(input op_e kind, input logic [7:0] d,
                                             input logic t6, input logic t2, input logic tmo);
    logic poll;
    logic et;
    poll = (kind == OP_PROG) ? ~d[7] : 1'b0;
    et   = (kind == OP_PROG) ? 1'b0 : t2;
    return {poll, t6, tmo, 2'b00, et, 2'b00};
  endfunction

  // One step of the unlock walk for positions that do not issue a command.
  function automatic seq_e seq_step(input seq_e s, input logic [BUS_AW-1:0] a,
                                    input logic [7:0] d);
    seq_e n;
    n = SQ_IDLE;
    if (d != D_RST) begin
      case (s)
        SQ_IDLE: if (a == UNLK_A && d == D_KEY1) n = SQ_K1;
        SQ_K1:   if (a == UNLK_B && d == D_KEY2) n = SQ_K2;
        SQ_K2: begin
          if (a == UNLK_A && d == D_PGM) n = SQ_PDATA;
          else if (a == UNLK_A && d == D_ERS) n = SQ_E3;
        end
        SQ_E3:   if (a == UNLK_A && d == D_KEY1) n = SQ_E4;
        SQ_E4:   if (a == UNLK_B && d == D_KEY2) n = SQ_E5;
        default: n = SQ_IDLE;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/fcsi_seq_decoder.sv
module fcsi_seq_decoder
  import fcsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              accept,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              cmd_v,
  output cmd_t              cmd,
  output seq_e              seq_state
);

  seq_e state, nxt;
  logic issue;
  op_e  kind;

  always_comb begin
    nxt   = state;
    issue = 1'b0;
    kind  = OP_NONE;
    if (wr_en && accept) begin
      if (state == SQ_PDATA) begin
        issue = 1'b1;
        kind  = OP_PROG;
        nxt   = SQ_IDLE;
      end else if (state == SQ_E5 && addr == UNLK_A && wdata == D_CHIP) begin
        issue = 1'b1;
        kind  = OP_CHIP;
        nxt   = SQ_IDLE;
      end else if (state == SQ_E5 && wdata == D_SECT) begin
        issue = 1'b1;
        kind  = OP_SECT;
        nxt   = SQ_IDLE;
      end else begin
        nxt = seq_step(state, addr, wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cmd_v <= 1'b0;
      cmd   <= '0;
    end else begin
      state <= nxt;
      cmd_v <= issue;
      if (issue) cmd <= '{kind: kind, addr: addr, data: wdata};
    end
  end

  assign seq_state = state;

endmodule

// File: rtl/fcsi_engine.sv
module fcsi_engine
  import fcsi_pkg::*;
#(
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 40,
  parameter int ARR_AW    = 6,
  parameter int SECT_W    = 2,
  parameter int TMO_W     = 16,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v,
  input  cmd_t              cmd,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic              idle,
  output logic              op_start,
  output logic              op_done,
  output logic              op_fail,
  output logic              op_refuse,
  output logic              stat_sel,
  output logic [7:0]        status,
  output logic              apply,
  output op_e               apply_kind,
  output logic [ARR_AW-1:0] apply_addr,
  output logic [7:0]        apply_data,
  output logic [NSECT-1:0]  apply_mask
);

  typedef enum logic [1:0] {EN_IDLE, EN_BUSY, EN_FAIL} eng_e;

  localparam logic [TMO_W-1:0] PROG_LEN  = TMO_W'(PROG_CYC);
  localparam logic [TMO_W-1:0] ERASE_LEN = TMO_W'(ERASE_CYC);
  localparam logic [TMO_W-1:0] ONE       = {{(TMO_W-1){1'b0}}, 1'b1};

  eng_e              st;
  logic [TMO_W-1:0]  cnt, dur_q;
  op_e               kind_q;
  logic [ARR_AW-1:0] addr_q;
  logic [7:0]        data_q;
  logic [NSECT-1:0]  mask_q;
  logic              t6, t2, tmo_q;

  logic [SECT_W-1:0] cmd_sec;
  logic              blocked;
  logic [NSECT-1:0]  new_mask;
  logic              last_cyc, tmo_hit;
  logic [TMO_W:0]    cnt_p1;

  assign cmd_sec = cmd.addr[ARR_AW-1 -: SECT_W];

  always_comb begin
    case (cmd.kind)
      OP_CHIP: begin blocked = &prot_mask;         new_mask = ~prot_mask; end
      OP_SECT: begin blocked = prot_mask[cmd_sec]; new_mask = NSECT'(1) << cmd_sec; end
      OP_PROG: begin blocked = prot_mask[cmd_sec]; new_mask = '0; end
      default: begin blocked = 1'b1;               new_mask = '0; end
    endcase
  end

  assign idle      = (st == EN_IDLE);
  assign op_start  = cmd_v && idle && !blocked;
  assign op_refuse = cmd_v && idle && blocked;

  assign cnt_p1   = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
  assign last_cyc = (cnt == dur_q - ONE);
  assign tmo_hit  = (tmo_limit != '0) && (cnt_p1 >= {1'b0, tmo_limit});
  assign op_done  = (st == EN_BUSY) && last_cyc;
  assign op_fail  = (st == EN_BUSY) && !last_cyc && tmo_hit;
  assign stat_sel = rd_en && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EN_IDLE;
      cnt    <= '0;
      dur_q  <= '0;
      kind_q <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      t6     <= 1'b0;
      t2     <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (st)
        EN_IDLE: begin
          if (op_start) begin
            st     <= EN_BUSY;
            cnt    <= '0;
            dur_q  <= (cmd.kind == OP_PROG) ? PROG_LEN : ERASE_LEN;
            kind_q <= cmd.kind;
            addr_q <= cmd.addr[ARR_AW-1:0];
            data_q <= cmd.data;
            mask_q <= new_mask;
            t6     <= 1'b0;
            t2     <= 1'b0;
            tmo_q  <= 1'b0;
          end
        end
        EN_BUSY: begin
          if (op_done) begin
            st <= EN_IDLE;
          end else if (op_fail) begin
            st    <= EN_FAIL;
            tmo_q <= 1'b1;
          end else begin
            cnt <= cnt_p1[TMO_W-1:0];
          end
        end
        EN_FAIL: begin
          if (wr_en && wdata == D_RST) begin
            st    <= EN_IDLE;
            tmo_q <= 1'b0;
          end
        end
        default: st <= EN_IDLE;
      endcase
      if (stat_sel) begin
        t6 <= ~t6;
        t2 <= ~t2;
      end
    end
  end

  assign status     = status_byte(kind_q, data_q, t6, t2, tmo_q);
  assign apply      = op_done;
  assign apply_kind = kind_q;
  assign apply_addr = addr_q;
  assign apply_data = data_q;
  assign apply_mask = mask_q;

endmodule

// File: rtl/fcsi_array.sv
module fcsi_array
  import fcsi_pkg::*;
#(
  parameter int ARR_AW  = 6,
  parameter int SECT_W  = 2,
  localparam int NSECT  = 1 << SECT_W,
  localparam int OFF_W  = ARR_AW - SECT_W,
  localparam int SB     = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  op_e               kind,
  input  logic [ARR_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [NSECT-1:0]  ers_mask,
  input  logic [ARR_AW-1:0] raddr,
  output logic [7:0]        rbyte
);

  logic [7:0] bank_rd [NSECT];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [7:0] cells [SB];
    logic       pgm_hit, ers_hit;

    assign pgm_hit = apply && (kind == OP_PROG) &&
                     (waddr[ARR_AW-1 -: SECT_W] == SECT_W'(s));
    assign ers_hit = apply && (kind != OP_PROG) && ers_mask[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SB; i++) cells[i] <= 8'hFF;
      end else if (ers_hit) begin
        for (int i = 0; i < SB; i++) cells[i] <= 8'hFF;
      end else if (pgm_hit) begin
        cells[waddr[OFF_W-1:0]] <= prog_merge(cells[waddr[OFF_W-1:0]], wdata);
      end
    end

    assign bank_rd[s] = cells[raddr[OFF_W-1:0]];
  end

  assign rbyte = bank_rd[raddr[ARR_AW-1 -: SECT_W]];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcsi_pkg::*;
#(
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 40,
  parameter int ARR_AW    = 6,
  parameter int SECT_W    = 2,
  parameter int TMO_W     = 16,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [10:0]       addr,
  input  logic [7:0]        wdata,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic [7:0]        rdata,
  output logic              ready
);

  logic              cmd_v;
  cmd_t              cmd;
  seq_e              seq_state;
  logic              eng_idle, op_start, op_done, op_fail, op_refuse, stat_sel;
  logic [7:0]        status;
  logic              apply;
  op_e               apply_kind;
  logic [ARR_AW-1:0] apply_addr;
  logic [7:0]        apply_data;
  logic [NSECT-1:0]  apply_mask;
  logic [7:0]        arr_byte;
  logic              dec_accept;

  // No new unlock cycle while a command is in flight or an operation runs.
  assign dec_accept = eng_idle && !cmd_v;

  fcsi_seq_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .accept    (dec_accept),
    .addr      (addr),
    .wdata     (wdata),
    .cmd_v     (cmd_v),
    .cmd       (cmd),
    .seq_state (seq_state)
  );

  fcsi_engine #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .ARR_AW    (ARR_AW),
    .SECT_W    (SECT_W),
    .TMO_W     (TMO_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_v      (cmd_v),
    .cmd        (cmd),
    .prot_mask  (prot_mask),
    .tmo_limit  (tmo_limit),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rd_en      (rd_en),
    .idle       (eng_idle),
    .op_start   (op_start),
    .op_done    (op_done),
    .op_fail    (op_fail),
    .op_refuse  (op_refuse),
    .stat_sel   (stat_sel),
    .status     (status),
    .apply      (apply),
    .apply_kind (apply_kind),
    .apply_addr (apply_addr),
    .apply_data (apply_data),
    .apply_mask (apply_mask)
  );

  fcsi_array #(
    .ARR_AW (ARR_AW),
    .SECT_W (SECT_W)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply),
    .kind     (apply_kind),
    .waddr    (apply_addr),
    .wdata    (apply_data),
    .ers_mask (apply_mask),
    .raddr    (addr[ARR_AW-1:0]),
    .rbyte    (arr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= stat_sel ? status : arr_byte;
  end

  assign ready = eng_idle;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic [7:0] rdata,
  input logic       op_start,
  input logic       op_done,
  input logic       op_fail,
  input logic       op_refuse,
  input logic       stat_sel
);

  logic sel_q, have_prev, prev6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
    end else begin
      sel_q <= stat_sel;
      if (op_start) begin
        have_prev <= 1'b0;
      end else if (sel_q) begin
        have_prev <= 1'b1;
        prev6     <= rdata[6];
      end
    end
  end

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !ready);

  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> ready);

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !op_start);

  assert_refuse_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_refuse |=> ready);

  assert_fail_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |=> !ready);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && have_prev) |-> (rdata[6] != prev6));

  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |=> (rdata[4:3] == 2'b00 && rdata[1:0] == 2'b00));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .rdata     (rdata),
  .op_start  (op_start),
  .op_done   (op_done),
  .op_fail   (op_fail),
  .op_refuse (op_refuse),
  .stat_sel  (stat_sel)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 12;
  localparam int ERASE_CYC  = 40;
  localparam int ARR_AW     = 6;
  localparam int SECT_W     = 2;
  localparam int TMO_W      = 16;
  localparam int NSECT      = 1 << SECT_W;
  localparam int DEPTH      = 1 << ARR_AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [10:0]      addr = '0;
  logic [7:0]       wdata = '0;
  logic [NSECT-1:0] prot_mask = '0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic [7:0]       rdata;
  logic             ready;

  int         checks = 0;
  int         fails = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(
    .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC),
    .ARR_AW (ARR_AW), .SECT_W (SECT_W), .TMO_W (TMO_W)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .prot_mask (prot_mask),
    .tmo_limit (tmo_limit), .rdata (rdata), .ready (ready)
  );

  function automatic int sec_of(input logic [10:0] a);
    return int'(a[ARR_AW-1 -: SECT_W]);
  endfunction

  // Program clears bits: a bit stays 1 only if both are 1.
  function automatic logic [7:0] exp_prog(input logic [7:0] old_v, input logic [7:0] d);
    return ~(~old_v | ~d);
  endfunction

  function automatic logic [7:0] exp_stat(input bit is_prog, input logic [7:0] d,
                                          input bit tog, input bit tmo);
    logic [7:0] v;
    v = 8'h00;
    if (is_prog) v[7] = !d[7];
    v[6] = tog;
    v[5] = tmo;
    if (!is_prog) v[2] = tog;
    return v;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_prog(input logic [10:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
    @(negedge clk);
  endtask

  task automatic do_erase(input logic [10:0] a, input logic [7:0] last);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(a, last);
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic model_prog(input logic [10:0] a, input logic [7:0] d);
    if (!prot_mask[sec_of(a)]) model[a[ARR_AW-1:0]] = exp_prog(model[a[ARR_AW-1:0]], d);
  endtask

  task automatic model_erase_sec(input int s);
    if (!prot_mask[s])
      for (int i = 0; i < DEPTH; i++) if ((i >> (ARR_AW - SECT_W)) == s) model[i] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int n;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready after reset", ready, 1);
    rd(11'h000, v); chk("R1 byte 0", v, 8'hFF);
    rd(11'h03F, v); chk("R1 byte 63", v, 8'hFF);

    // R2 and R6 directed program
    do_prog(11'h005, 8'h3C); model_prog(11'h005, 8'h3C);
    chk("R6 ready low after program", ready, 0);
    wait_ready(n); chk("R6 program length", n, PROG_CYC);
    rd(11'h005, v); chk("R2 program result", v, model[5]);
    do_prog(11'h005, 8'h0F); model_prog(11'h005, 8'h0F);
    wait_ready(n);
    rd(11'h005, v); chk("R2 AND merge", v, 8'h0C);

    // R7 R8 status during program
    do_prog(11'h010, 8'h5A); model_prog(11'h010, 8'h5A);
    rd(11'h010, v);  chk("R7 program status first", v, exp_stat(1, 8'h5A, 0, 0));
    rd(11'h010, v2); chk("R8 program status second", v2, exp_stat(1, 8'h5A, 1, 0));
    wait_ready(n);
    rd(11'h010, v); chk("R2 program 0x10", v, 8'h5A);

    // R4 R7 R8 sector erase of sector 0
    do_erase(11'h008, 8'h30); model_erase_sec(0);
    rd(11'h008, v);  chk("R7 erase status first", v, exp_stat(0, 8'h00, 0, 0));
    rd(11'h008, v2); chk("R8 erase status second", v2, exp_stat(0, 8'h00, 1, 0));
    wait_ready(n);
    rd(11'h005, v); chk("R4 sector 0 erased", v, 8'hFF);
    rd(11'h010, v); chk("R4 sector 1 kept", v, 8'h5A);

    // R6 erase length
    do_erase(11'h02C, 8'h30); model_erase_sec(2);
    wait_ready(n); chk("R6 erase length", n, ERASE_CYC);

    // R5 abandoned and mismatched sequences
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80); wr(11'h555, 8'hF0);
    wr(11'h2AA, 8'h55); wr(11'h555, 8'h10); @(negedge clk);
    chk("R5 reset mid erase keeps ready", ready, 1);
    rd(11'h010, v); chk("R5 reset mid erase no change", v, 8'h5A);
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h010, 8'h00);
    @(negedge clk);
    chk("R5 mismatch keeps ready", ready, 1);
    rd(11'h010, v); chk("R5 mismatch no program", v, 8'h5A);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hF0); wr(11'h010, 8'h00);
    @(negedge clk);
    rd(11'h010, v); chk("R5 reset at third cycle", v, 8'h5A);

    // R10 protection
    prot_mask = 4'b0010;
    do_prog(11'h011, 8'h00);
    chk("R10 protected program refused", ready, 1);
    rd(11'h011, v); chk("R10 protected byte", v, 8'hFF);
    do_erase(11'h010, 8'h30);
    chk("R10 protected erase refused", ready, 1);
    rd(11'h010, v); chk("R10 protected sector kept", v, 8'h5A);

    // R3 chip erase with R9 writes during busy
    do_prog(11'h030, 8'h00); model_prog(11'h030, 8'h00); wait_ready(n);
    do_erase(11'h555, 8'h10);
    chk("R3 chip erase busy", ready, 0);
    do_prog(11'h020, 8'h00); wr(11'h000, 8'hF0);
    chk("R9 still busy after writes", ready, 0);
    wait_ready(n);
    for (int s = 0; s < NSECT; s++) model_erase_sec(s);
    rd(11'h020, v); chk("R9 busy program ignored", v, 8'hFF);
    rd(11'h030, v); chk("R3 unprotected erased", v, 8'hFF);
    rd(11'h010, v); chk("R3 protected kept", v, 8'h5A);
    prot_mask = 4'b1111;
    do_erase(11'h555, 8'h10);
    chk("R10 all protected chip erase refused", ready, 1);
    prot_mask = '0;

    // R11 timeout below length
    tmo_limit = TMO_W'(PROG_CYC - 1);
    do_prog(11'h031, 8'h00);
    repeat (PROG_CYC + 8) @(negedge clk);
    chk("R11 ready low after timeout", ready, 0);
    rd(11'h031, v); chk("R11 timeout status", v, exp_stat(1, 8'h00, 0, 1));
    wr(11'h000, 8'hF0); @(negedge clk);
    chk("R11 reset clears failure", ready, 1);
    rd(11'h031, v); chk("R11 array unchanged", v, model[8'h31]);
    // R11 limit equal to length completes
    tmo_limit = TMO_W'(PROG_CYC);
    do_prog(11'h031, 8'h81); model_prog(11'h031, 8'h81);
    wait_ready(n); chk("R11 limit equal completes", n, PROG_CYC);
    rd(11'h031, v); chk("R11 program landed", v, model[8'h31]);
    tmo_limit = '0;

    // Constrained random mix
    for (int it = 0; it < 60; it++) begin
      logic [10:0] a;
      logic [7:0]  d;
      int          pick;
      a = 11'($urandom_range(0, DEPTH - 1));
      d = 8'($urandom);
      pick = int'($urandom_range(0, 9));
      prot_mask = ($urandom_range(0, 3) == 0) ? NSECT'($urandom) : '0;
      if (pick < 6) begin
        do_prog(a, d); model_prog(a, d); wait_ready(n);
        rd(a, v); chk("R2 random program", v, model[a[ARR_AW-1:0]]);
      end else if (pick < 8) begin
        do_erase(a, 8'h30); model_erase_sec(sec_of(a)); wait_ready(n);
        rd(a, v); chk("R4 random sector erase", v, model[a[ARR_AW-1:0]]);
      end else begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] g;
          g = 8'($urandom);
          if (g == 8'hAA) g = 8'h00;
          wr(11'($urandom), g);
        end
        wr(a, d); @(negedge clk);
        chk("R5 random garbage ready", ready, 1);
        rd(a, v); chk("R5 random garbage no change", v, model[a[ARR_AW-1:0]]);
      end
    end
    prot_mask = '0;

    summary();
    $finish;
  end

endmodule